// File: doc/BRIEF.md
# Console Receive Register Interface

This block connects a byte-wide serial receiver to a processor's register bus. The receiver hands over one character, or a line break, per strobe. The block keeps the most recent one in a 16-bit data word, together with error flags. A status word reports whether an unread character is waiting and whether interrupts are enabled. An interrupt request goes up when a character arrives with interrupts enabled. A received break can also ask the processor to halt.

Software polls or takes the interrupt, then reads the data word. That read hands back the character with its error flags and clears the waiting condition. A character that has not been read is protected for a configurable number of clock cycles, counted from its arrival. After that window it may be replaced, and the replacement is marked as an overrun. The bit-level receiver, the baud timing and the interrupt controller sit outside this block.

Top module: `cons_rx_port`

## Requirements
- R1: A read at address 0 (status) returns the waiting flag in bit 7 and the interrupt-enable flag in bit 6; every other bit reads 0.
- R2: A bus write to status changes only the enable flag (taken from write bit 6); the waiting flag cannot be written, and a write to address 1 (data) changes nothing.
- R3: The data word carries the character in bits 7:0, a summary error in bit 15, overrun in bit 14, framing in bit 13 and break in bit 10. A character accepted with nothing waiting has bits 15:8 clear, while one that replaces an unread character has bits 15 and 14 set.
- R4: A read at address 1 while a character waits returns the full word, including its error bits. On that clock edge it clears the waiting flag, bits 15:8 of the stored word and the interrupt request. A read with nothing waiting changes nothing.
- R5: An accepted character sets the waiting flag on the next edge, and the interrupt request rises on the same edge when the enable flag is 1.
- R6: While a character waits, new input is refused until HOLD_CYCLES clock cycles have passed since it was accepted; input presented exactly HOLD_CYCLES cycles after the accepting edge is taken.
- R7: An accepted break stores the word 0xA400 (bits 15, 13 and 10). halt_req pulses high for one cycle after it if and only if halt_enable was 1.
- R8: Writing the enable flag as 0 drops the interrupt request. Writing it as 1 while a character waits and the flag was 0 raises the request on the next edge.
- R9: With cfg_eight_bit at 0, bit 7 of each stored character is forced to 0; with it at 1 all eight bits are kept.
- R10: After a synchronous active-high reset, the data word, the waiting flag, the enable flag, the interrupt request and halt_req are all 0.
- R11: A break and a character strobed in the same cycle store the break. An accepted input and a data read in the same cycle leave the new input waiting, with no overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_eight_bit | input | 1 | 1 keeps all eight character bits, 0 clears bit 7 |
| halt_enable | input | 1 | Lets an accepted break raise halt_req |
| rx_valid | input | 1 | Receiver offers a character this cycle |
| rx_data | input | 8 | Offered character |
| rx_break | input | 1 | Receiver reports a line break this cycle |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects status, 1 selects data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| halt_req | output | 1 | One-cycle halt request after an enabled break |

## Verification
bus_rdata follows bus_addr within the same cycle, so the bench samples it at the falling edge without any clock between the address change and the sample. The effects of a strobe, a read or a write all appear one rising edge later: waiting flag, stored word, enable, irq and halt_req. The bench drives stimulus at a falling edge, lets one rising edge pass and samples at the next falling edge. Its behavioural model advances on the same rising edge and is compared with every output on every cycle. The hold-off boundary is checked by presenting input at the edge exactly HOLD_CYCLES-1 and then HOLD_CYCLES cycles after the accepting edge.

// File: rtl/cons_rx_pkg.sv
package cons_rx_pkg;
  localparam int unsigned POS_ERR  = 15;
  localparam int unsigned POS_OVR  = 14;
  localparam int unsigned POS_FRM  = 13;
  localparam int unsigned POS_BRK  = 10;
  localparam int unsigned POS_WAIT = 7;
  localparam int unsigned POS_IE   = 6;

  typedef logic [15:0] word_t;
  typedef logic [7:0]  char_t;

  // Character width selection: seven-bit mode drops the top bit.
  function automatic char_t fold_char(input char_t c, input logic eight);
    char_t r;
    r = c;
    if (!eight) r[7] = 1'b0;
    return r;
  endfunction

  // Fixed word stored for a line break.
  function automatic word_t break_word();
    word_t w;
    w = '0;
    w[POS_ERR] = 1'b1;
    w[POS_FRM] = 1'b1;
    w[POS_BRK] = 1'b1;
    return w;
  endfunction

  // Word stored for an ordinary character, overrun when it replaces an unread one.
  function automatic word_t char_word(input char_t c, input logic ovr);
    word_t w;
    w = {8'h00, c};
    w[POS_ERR] = ovr;
    w[POS_OVR] = ovr;
    return w;
  endfunction

  function automatic word_t status_word(input logic waiting, input logic ie);
    word_t w;
    w = '0;
    w[POS_WAIT] = waiting;
    w[POS_IE]   = ie;
    return w;
  endfunction
endpackage

// File: rtl/cons_rx_holdoff.sv
module cons_rx_holdoff #(
  parameter int unsigned HOLD_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  output logic expired
);
  localparam int unsigned CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] free_q;
  logic [CW-1:0] stamp_q;
  logic [CW-1:0] elapsed;
  logic          reached;
  logic          sticky_q;

  assign elapsed = free_q - stamp_q;
  assign reached = (elapsed >= CW'(HOLD_CYCLES));
  assign expired = sticky_q | reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q   <= '0;
      stamp_q  <= '0;
      sticky_q <= 1'b0;
    end else begin
      free_q <= free_q + 1'b1;
      if (capture) begin
        stamp_q  <= free_q;
        sticky_q <= 1'b0;
      end else if (reached) begin
        sticky_q <= 1'b1;
      end
    end
  end

  AST_FRESH_PROTECTED: assert property (@(posedge clk) disable iff (rst)
    (capture && HOLD_CYCLES > 1) |=> !expired) else $error("fresh capture expired"); // R6
  AST_EXPIRY_STICKS: assert property (@(posedge clk) disable iff (rst)
    (expired && !capture) |=> expired) else $error("expiry lost"); // R6
endmodule

// File: rtl/cons_rx_buffer.sv
module cons_rx_buffer
  import cons_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  load_break,
  input  char_t load_char,
  input  logic  load_ovr,
  input  logic  drain,
  output word_t word_q,
  output logic  full_q
);
  word_t word_d;
  logic  full_d;

  always_comb begin
    word_d = word_q;
    full_d = full_q;
    if (load) begin
      word_d = load_break ? break_word() : char_word(load_char, load_ovr);
      full_d = 1'b1;
    end else if (drain) begin
      word_d = {8'h00, word_q[7:0]};
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      word_q <= word_d;
      full_q <= full_d;
    end
  end

  AST_FULL_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> full_q) else $error("load did not mark full"); // R5
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (drain && !load) |=> (!full_q && word_q[15:8] == 8'h00)) else $error("drain incomplete"); // R4
  AST_BREAK_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (load && load_break) |=> (word_q == 16'hA400)) else $error("break word wrong"); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && !drain) |=> ($stable(word_q) && $stable(full_q))) else $error("idle change"); // R2
endmodule

// File: rtl/cons_rx_irq.sv
module cons_rx_irq (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_ie,
  input  logic raise,
  input  logic drain,
  input  logic pending,
  output logic ie_q,
  output logic irq_q
);
  logic ie_d;
  logic arm;
  logic irq_d;

  assign ie_d = cfg_wr ? cfg_ie : ie_q;
  assign arm  = cfg_wr & cfg_ie & pending & ~ie_q;

  always_comb begin
    irq_d = irq_q;
    if (arm) irq_d = 1'b1;
    if (raise && ie_d) irq_d = 1'b1;
    if (drain && !raise) irq_d = 1'b0;
    if (cfg_wr && !cfg_ie) irq_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      irq_q <= irq_d;
    end
  end

  AST_IE_OFF_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_ie) |=> !irq_q) else $error("irq kept with enable off"); // R8
  AST_ARM_RAISES: assert property (@(posedge clk) disable iff (rst)
    (arm && !drain) |=> irq_q) else $error("late enable did not raise"); // R8
  AST_IRQ_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> pending) else $error("irq without waiting char"); // R5
endmodule

// File: rtl/cons_rx_port.sv
module cons_rx_port
  import cons_rx_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 50_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_eight_bit,
  input  logic        halt_enable,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_break,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        halt_req
);
  // Named internal events
  logic  rx_any;
  logic  expired;
  logic  accept;
  logic  drain;
  logic  overrun;
  logic  stat_wr;
  logic  waiting;
  logic  ie;
  word_t word;
  char_t folded;
  logic  halt_q;

  assign rx_any  = rx_valid | rx_break;
  assign accept  = rx_any & (~waiting | expired);
  assign drain   = bus_rd & bus_addr & waiting;
  assign overrun = waiting & ~drain;
  assign stat_wr = bus_wr & ~bus_addr;
  assign folded  = fold_char(rx_data, cfg_eight_bit);

  cons_rx_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (accept),
    .expired (expired)
  );

  cons_rx_buffer u_buf (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_break (rx_break),
    .load_char  (folded),
    .load_ovr   (overrun),
    .drain      (drain),
    .word_q     (word),
    .full_q     (waiting)
  );

  cons_rx_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (stat_wr),
    .cfg_ie  (bus_wdata[POS_IE]),
    .raise   (accept),
    .drain   (drain),
    .pending (waiting),
    .ie_q    (ie),
    .irq_q   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) halt_q <= 1'b0;
    else     halt_q <= accept & rx_break & halt_enable;
  end

  assign halt_req  = halt_q;
  assign bus_rdata = bus_addr ? word : status_word(waiting, ie);

  AST_STATUS_SPARSE: assert property (@(posedge clk) disable iff (rst)
    !bus_addr |-> ((bus_rdata & 16'hFF3F) == 16'h0000)) else $error("status spare bits set"); // R1
  AST_HALT_GATED: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(halt_enable && rx_break)) else $error("halt without enabled break"); // R7
  AST_PROTECTED: assert property (@(posedge clk) disable iff (rst)
    (rx_any && waiting && !expired && !drain) |=> $stable(word)) else $error("protected char replaced"); // R6
  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req || $past(rx_break)) else $error("halt held"); // R7
endmodule

// File: tb/cons_rx_port_bench.sv
module cons_rx_port_bench;
  localparam int HOLD = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_eight_bit = 1'b1;
  logic        halt_enable = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_break = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        irq;
  logic        halt_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference model state
  int m_word = 0;
  bit m_wait = 0;
  bit m_ie = 0;
  bit m_irq = 0;
  bit m_halt = 0;
  int m_age = 0;

  always #5 clk = ~clk;

  cons_rx_port #(.HOLD_CYCLES(HOLD)) u_cons_rx_port (
    .clk(clk), .rst(rst), .cfg_eight_bit(cfg_eight_bit), .halt_enable(halt_enable),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .halt_req(halt_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_read(input bit addr);
    if (addr) return m_word;
    return (m_wait ? 128 : 0) + (m_ie ? 64 : 0);
  endfunction

  task automatic model_edge();
    bit took, clr, ie_next, irq_next;
    int ch;
    if (rst) begin
      m_word = 0; m_wait = 0; m_ie = 0; m_irq = 0; m_halt = 0; m_age = 0;
      return;
    end
    took = (rx_valid || rx_break) && (!m_wait || m_age >= HOLD);
    clr = bus_rd && bus_addr && m_wait;
    ie_next = (bus_wr && !bus_addr) ? bus_wdata[6] : m_ie;
    irq_next = m_irq;
    if (bus_wr && !bus_addr && bus_wdata[6] && m_wait && !m_ie) irq_next = 1;
    if (took && ie_next) irq_next = 1;
    if (clr && !took) irq_next = 0;
    if (bus_wr && !bus_addr && !bus_wdata[6]) irq_next = 0;
    m_halt = took && rx_break && halt_enable;
    if (took) begin
      if (rx_break) m_word = 'hA400;
      else begin
        ch = cfg_eight_bit ? int'(rx_data) : int'(rx_data) % 128;
        m_word = ch + ((m_wait && !clr) ? 'hC000 : 0);
      end
      m_wait = 1;
      m_age = 1;
    end else begin
      if (clr) begin m_word = m_word % 256; m_wait = 0; end
      if (m_age < 1000000) m_age++;
    end
    m_ie = ie_next;
    m_irq = irq_next;
  endtask

  // One rising edge, model update, then compare every output at the falling edge.
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R1/R3 model rdata", int'(bus_rdata), model_read(bus_addr));
    check("R5/R8 model irq", int'(irq), int'(m_irq));
    check("R7 model halt_req", int'(halt_req), int'(m_halt));
  endtask

  task automatic idle();
    rx_valid = 0; rx_break = 0; bus_rd = 0; bus_wr = 0;
  endtask

  task automatic peek(input bit addr, output int val);
    bus_addr = addr;
    #1;
    val = int'(bus_rdata);
  endtask

  task automatic send(input logic [7:0] c);
    rx_valid = 1; rx_data = c;
    step();
    idle();
  endtask

  task automatic write_status(input logic [15:0] v);
    bus_wr = 1; bus_addr = 0; bus_wdata = v;
    step();
    idle();
  endtask

  task automatic write_data(input logic [15:0] v);
    bus_wr = 1; bus_addr = 1; bus_wdata = v;
    step();
    idle();
  endtask

  task automatic read_data(output int val);
    bus_rd = 1; bus_addr = 1;
    #1;
    val = int'(bus_rdata);
    step();
    idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    @(negedge clk);
    step(); step();
    rst = 0;
    step();
    // R10 reset state
    peek(0, v); check("R10 status after reset", v, 0);
    peek(1, v); check("R10 data after reset", v, 0);
    check("R10 irq after reset", int'(irq), 0);
    check("R10 halt_req after reset", int'(halt_req), 0);

    // R1, R2: only enable writable
    write_status(16'hFFFF);
    peek(0, v); check("R1 R2 status after all-ones write", v, 'h0040);
    write_status(16'h0000);
    peek(0, v); check("R2 enable cleared", v, 0);

    // R5, R3, R4 with enable off, eight-bit mode
    send(8'hC1);
    peek(0, v); check("R5 waiting set", v, 'h0080);
    peek(1, v); check("R3 fresh char word", v, 'h00C1);
    check("R5 no irq while disabled", int'(irq), 0);
    // R2: data write ignored
    write_data(16'h1234);
    peek(1, v); check("R2 data write ignored", v, 'h00C1);
    read_data(v); check("R4 read returns char", v, 'h00C1);
    peek(0, v); check("R4 waiting cleared", v, 0);
    read_data(v); check("R4 empty read harmless", v, 'h00C1);
    peek(0, v); check("R4 empty read keeps status", v, 0);

    // R5 irq with enable on
    write_status(16'h0040);
    send(8'h5A);
    check("R5 irq raised", int'(irq), 1);
    read_data(v); check("R4 read value", v, 'h005A);
    check("R4 irq dropped by read", int'(irq), 0);

    // R9 seven-bit mode
    cfg_eight_bit = 0;
    send(8'hC1);
    peek(1, v); check("R9 bit 7 masked", v, 'h0041);
    read_data(v);
    cfg_eight_bit = 1;

    // R6 hold-off boundary and R3 overrun
    send(8'h11);
    for (int i = 0; i < HOLD - 2; i++) step();
    send(8'h22);
    peek(1, v); check("R6 refused inside window", v, 'h0011);
    send(8'h22);
    peek(1, v); check("R6 R3 accepted at window with overrun", v, 'hC022);
    read_data(v); check("R4 read keeps error bits", v, 'hC022);
    peek(1, v); check("R4 error bits cleared", v, 'h0022);

    // R8 late enable and disable
    write_status(16'h0000);
    send(8'h33);
    check("R8 no irq while disabled", int'(irq), 0);
    write_status(16'h0040);
    check("R8 late enable raises irq", int'(irq), 1);
    write_status(16'h0000);
    check("R8 disable drops irq", int'(irq), 0);
    read_data(v);

    // R7 break with halt enabled and disabled
    halt_enable = 1;
    rx_break = 1;
    step();
    idle();
    check("R7 halt pulse", int'(halt_req), 1);
    peek(1, v); check("R7 break word", v, 'hA400);
    step();
    check("R7 halt single cycle", int'(halt_req), 0);
    read_data(v);
    halt_enable = 0;
    rx_break = 1;
    step();
    idle();
    check("R7 no halt when disabled", int'(halt_req), 0);
    read_data(v); check("R7 break read", v, 'hA400);

    // R11 break wins over character
    rx_break = 1; rx_valid = 1; rx_data = 8'h44;
    step();
    idle();
    peek(1, v); check("R11 break over char", v, 'hA400);
    for (int i = 0; i < HOLD; i++) step();
    // R11 accept and read in same cycle
    rx_valid = 1; rx_data = 8'h55; bus_rd = 1; bus_addr = 1;
    step();
    idle();
    peek(1, v); check("R11 new char, no overrun", v, 'h0055);
    peek(0, v); check("R11 still waiting", v, 'h0080);

    // Reset again mid-operation
    rst = 1; step(); rst = 0; step();
    peek(0, v); check("R10 status after second reset", v, 0);
    peek(1, v); check("R10 data after second reset", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule